// File: doc/BRIEF.md
# Prescaled Up/Down Reload Timer

This block is a 16-bit timer that advances once per tick of a 10-bit prescaler. The prescaler counts up from a programmable start value to its all-ones top, emits one tick there and starts again from the start value. On each tick the timer either steps up or steps down, depending on a direction bit. A programmable 16-bit reload value sets where counting up wraps and what counting down reloads. Each wrap or reload sets a sticky overflow flag, which software clears by writing a one to it.

Software reaches the block through a byte-wide register port with eight addresses. The timer is read live at any time. A read of the low byte freezes the high byte in a holding register, so the two halves of a 16-bit read match. A timer write is assembled from a buffered high byte and the low byte, then held pending until the next prescaler tick, when it replaces the count. A small state machine holds the run state: STOPPED, COUNT_UP or COUNT_DOWN. Every write to the control address moves it. A mode field of 0 leads to STOPPED. A non-zero mode leads to COUNT_UP when the direction bit is 0 and to COUNT_DOWN when it is 1. The new state applies from the clock edge of the write, so counting reverses on the very next cycle. No other event changes the state.

Top module: `prescaled_reload_timer`

## Requirements
- R1: After reset the timer, the reload value, the control field (address 6) and the overflow flag all read zero.
- R2: The prescaler counter moves from its start value (10 bits: address 4 low byte, bits 1:0 of address 5 high) to 0x3FF. It ticks once on reaching 0x3FF, so the timer advances every 1024 minus start-value cycles, and only on ticks.
- R3: A write to address 4 or 5 restarts the prescaler at once from the newly formed start value, and no tick occurs on that write cycle.
- R4: While the mode field (control bits 1:0) is 00 the timer holds its value. Modes 01, 10 and 11 all run it.
- R5: Control bit 2 selects the direction, 0 up and 1 down. A change takes effect from the edge of the control write, so the next tick already steps the new way.
- R6: Counting up, a tick at the limit sets the timer to 0 and sets the flag. The limit is the reload value (address 2 low, address 3 high), or 0xFFFF when the reload value is 0.
- R7: Counting down, a tick with the timer at 0 loads the limit and sets the flag.
- R8: The overflow flag (bit 0 of address 7, also on port ovf_flag) stays set until a write of 1 to bit 0 of address 7. A write of 0 leaves it unchanged.
- R9: A write to address 1 is buffered. A write to address 0 then forms the pending value, which replaces the timer on the next tick even when stopped, and not before.
- R10: A read strobe on address 0 returns the live low byte and captures the live high byte. Address 1 then reads that captured byte, not the live one.
- R11: When a pending value and a wrap fall on the same tick, the timer takes the pending value and the flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect on address 0 only) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| timer_value | output | 16 | Live timer count |
| ovf_flag | output | 1 | Sticky overflow/underflow flag |

## Verification
The bench places a timer write so that its load has to wait three cycles for a tick while the timer is stopped. A design that loads at once shows the new value too early. A direction change is checked on the tick right after the control write, where a design that decodes direction one cycle late steps the old way once more. A pending value is made to coincide with an up-count at the limit, and a wrong priority there shows either 0 or a set flag. A prescaler restart is checked by the phase of the following ticks, and a coherent read is checked by letting the high byte roll over between the low and high reads.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;

    localparam int TIMER_W = 16;
    localparam int BYTE_W  = 8;

    typedef enum logic [2:0] {
        A_CNT_LO = 3'd0,
        A_CNT_HI = 3'd1,
        A_RLD_LO = 3'd2,
        A_RLD_HI = 3'd3,
        A_PSC_LO = 3'd4,
        A_PSC_HI = 3'd5,
        A_CTRL   = 3'd6,
        A_FLAG   = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        ST_STOPPED    = 2'd0,
        ST_COUNT_UP   = 2'd1,
        ST_COUNT_DOWN = 2'd2
    } run_state_e;

endpackage

// File: rtl/ptimer_prescaler.sv
module ptimer_prescaler #(
    parameter int PSC_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PSC_W-1:0] reload_val,
    input  logic             restart,
    input  logic [PSC_W-1:0] restart_val,
    output logic             tick
);
    localparam logic [PSC_W-1:0] TOP = '1;
    localparam logic [PSC_W-1:0] ONE = {{(PSC_W-1){1'b0}}, 1'b1};

    logic [PSC_W-1:0] cnt_q;
    logic             at_top;

    assign at_top = (cnt_q == TOP);
    // A restart cycle never produces a tick.
    assign tick   = at_top && !restart;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= restart_val;
        end else if (at_top) begin
            cnt_q <= reload_val;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end

endmodule

// File: rtl/ptimer_regs.sv
module ptimer_regs
    import ptimer_pkg::*;
#(
    parameter int PSC_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [2:0]         bus_addr,
    input  logic [BYTE_W-1:0]  bus_wdata,
    output logic [BYTE_W-1:0]  bus_rdata,
    input  logic [TIMER_W-1:0] timer_q,
    input  logic               flag_q,
    output logic               pend_wr,
    output logic [TIMER_W-1:0] pend_val,
    output logic [TIMER_W-1:0] rld_val,
    output logic [PSC_W-1:0]   psc_reload,
    output logic               psc_restart,
    output logic [PSC_W-1:0]   psc_restart_val,
    output logic               ctrl_wr,
    output logic [1:0]         ctrl_mode,
    output logic               ctrl_dir,
    output logic               flag_clr
);
    localparam int PSC_HI_W = PSC_W - BYTE_W;
    localparam int PAD_W    = BYTE_W - PSC_HI_W;

    reg_addr_e          addr;
    logic [BYTE_W-1:0]  hi_buf_q;
    logic [BYTE_W-1:0]  hi_hold_q;
    logic [TIMER_W-1:0] rld_q;
    logic [PSC_W-1:0]   psc_q;
    logic [1:0]         mode_q;
    logic               dir_q;

    assign addr = reg_addr_e'(bus_addr);

    // Strobes and data handed to the other sub-blocks.
    assign pend_wr     = bus_wr && (addr == A_CNT_LO);
    assign pend_val    = {hi_buf_q, bus_wdata};
    assign psc_restart = bus_wr && ((addr == A_PSC_LO) || (addr == A_PSC_HI));
    assign psc_restart_val = (addr == A_PSC_LO)
                           ? {psc_q[PSC_W-1:BYTE_W], bus_wdata}
                           : {bus_wdata[PSC_HI_W-1:0], psc_q[BYTE_W-1:0]};
    assign ctrl_wr     = bus_wr && (addr == A_CTRL);
    assign ctrl_mode   = bus_wdata[1:0];
    assign ctrl_dir    = bus_wdata[2];
    assign flag_clr    = bus_wr && (addr == A_FLAG) && bus_wdata[0];
    assign rld_val     = rld_q;
    assign psc_reload  = psc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_buf_q  <= '0;
            hi_hold_q <= '0;
            rld_q     <= '0;
            psc_q     <= '0;
            mode_q    <= '0;
            dir_q     <= 1'b0;
        end else begin
            if (bus_rd && (addr == A_CNT_LO)) begin
                hi_hold_q <= timer_q[TIMER_W-1:BYTE_W];
            end
            if (bus_wr) begin
                case (addr)
                    A_CNT_HI: hi_buf_q <= bus_wdata;
                    A_RLD_LO: rld_q[BYTE_W-1:0] <= bus_wdata;
                    A_RLD_HI: rld_q[TIMER_W-1:BYTE_W] <= bus_wdata;
                    A_PSC_LO: psc_q <= psc_restart_val;
                    A_PSC_HI: psc_q <= psc_restart_val;
                    A_CTRL: begin
                        mode_q <= bus_wdata[1:0];
                        dir_q  <= bus_wdata[2];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (addr)
            A_CNT_LO: bus_rdata = timer_q[BYTE_W-1:0];
            A_CNT_HI: bus_rdata = hi_hold_q;
            A_RLD_LO: bus_rdata = rld_q[BYTE_W-1:0];
            A_RLD_HI: bus_rdata = rld_q[TIMER_W-1:BYTE_W];
            A_PSC_LO: bus_rdata = psc_q[BYTE_W-1:0];
            A_PSC_HI: bus_rdata = {{PAD_W{1'b0}}, psc_q[PSC_W-1:BYTE_W]};
            A_CTRL:   bus_rdata = {5'b0, dir_q, mode_q};
            A_FLAG:   bus_rdata = {7'b0, flag_q};
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ptimer_core.sv
module ptimer_core
    import ptimer_pkg::*;
#(
    parameter int TW = TIMER_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          ctrl_wr,
    input  logic [1:0]    ctrl_mode,
    input  logic          ctrl_dir,
    input  logic          pend_wr,
    input  logic [TW-1:0] pend_val,
    input  logic [TW-1:0] rld_val,
    input  logic          flag_clr,
    output logic [TW-1:0] timer_q,
    output logic          flag_q
);
    localparam logic [TW-1:0] ONE = {{(TW-1){1'b0}}, 1'b1};

    run_state_e    state_q;
    run_state_e    state_d;
    logic [TW-1:0] limit;
    logic [TW-1:0] timer_d;
    logic          wrap;
    logic [TW-1:0] pend_q;
    logic          pend_valid_q;

    // Run-state transitions: every control write decides the new state.
    always_comb begin
        state_d = state_q;
        if (ctrl_wr) begin
            if (ctrl_mode == 2'b00) begin
                state_d = ST_STOPPED;
            end else if (ctrl_dir) begin
                state_d = ST_COUNT_DOWN;
            end else begin
                state_d = ST_COUNT_UP;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STOPPED;
        end else begin
            state_q <= state_d;
        end
    end

    assign limit = (rld_val == '0) ? '1 : rld_val;

    // Per-state count outputs.
    always_comb begin
        timer_d = timer_q;
        wrap    = 1'b0;
        if (tick) begin
            unique case (state_q)
                ST_STOPPED: ;
                ST_COUNT_UP: begin
                    if (timer_q == limit) begin
                        timer_d = '0;
                        wrap    = 1'b1;
                    end else begin
                        timer_d = timer_q + ONE;
                    end
                end
                ST_COUNT_DOWN: begin
                    if (timer_q == '0) begin
                        timer_d = limit;
                        wrap    = 1'b1;
                    end else begin
                        timer_d = timer_q - ONE;
                    end
                end
                default: ;
            endcase
            if (pend_valid_q) begin
                timer_d = pend_q;
                wrap    = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer_q      <= '0;
            pend_q       <= '0;
            pend_valid_q <= 1'b0;
            flag_q       <= 1'b0;
        end else begin
            timer_q <= timer_d;
            if (pend_wr) begin
                pend_q       <= pend_val;
                pend_valid_q <= 1'b1;
            end else if (tick) begin
                pend_valid_q <= 1'b0;
            end
            if (wrap) begin
                flag_q <= 1'b1;
            end else if (flag_clr) begin
                flag_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/prescaled_reload_timer.sv
module prescaled_reload_timer
    import ptimer_pkg::*;
#(
    parameter int PSC_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [2:0]         bus_addr,
    input  logic [BYTE_W-1:0]  bus_wdata,
    output logic [BYTE_W-1:0]  bus_rdata,
    output logic [TIMER_W-1:0] timer_value,
    output logic               ovf_flag
);
    logic               psc_tick;
    logic [PSC_W-1:0]   psc_reload;
    logic               psc_restart;
    logic [PSC_W-1:0]   psc_restart_val;
    logic               pend_wr;
    logic [TIMER_W-1:0] pend_val;
    logic [TIMER_W-1:0] rld_val;
    logic               ctrl_wr;
    logic [1:0]         ctrl_mode;
    logic               ctrl_dir;
    logic               flag_clr;

    ptimer_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk         (clk),
        .rst_n       (rst_n),
        .reload_val  (psc_reload),
        .restart     (psc_restart),
        .restart_val (psc_restart_val),
        .tick        (psc_tick)
    );

    ptimer_regs #(.PSC_W(PSC_W)) u_regs (
        .clk             (clk),
        .rst_n           (rst_n),
        .bus_wr          (bus_wr),
        .bus_rd          (bus_rd),
        .bus_addr        (bus_addr),
        .bus_wdata       (bus_wdata),
        .bus_rdata       (bus_rdata),
        .timer_q         (timer_value),
        .flag_q          (ovf_flag),
        .pend_wr         (pend_wr),
        .pend_val        (pend_val),
        .rld_val         (rld_val),
        .psc_reload      (psc_reload),
        .psc_restart     (psc_restart),
        .psc_restart_val (psc_restart_val),
        .ctrl_wr         (ctrl_wr),
        .ctrl_mode       (ctrl_mode),
        .ctrl_dir        (ctrl_dir),
        .flag_clr        (flag_clr)
    );

    ptimer_core #(.TW(TIMER_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (psc_tick),
        .ctrl_wr   (ctrl_wr),
        .ctrl_mode (ctrl_mode),
        .ctrl_dir  (ctrl_dir),
        .pend_wr   (pend_wr),
        .pend_val  (pend_val),
        .rld_val   (rld_val),
        .flag_clr  (flag_clr),
        .timer_q   (timer_value),
        .flag_q    (ovf_flag)
    );

endmodule

// File: rtl/ptimer_checker.sv
module ptimer_checker
    import ptimer_pkg::*;
#(
    parameter int TW = TIMER_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input run_state_e    state,
    input logic          pend_valid,
    input logic [TW-1:0] pend_val,
    input logic [TW-1:0] limit,
    input logic [TW-1:0] timer,
    input logic          flag
);
    assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(timer));

    assert_stop_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state == ST_STOPPED && !pend_valid) |=> $stable(timer));

    assert_up_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state == ST_COUNT_UP && !pend_valid && timer != limit)
        |=> timer == TW'($past(timer) + TW'(1)));

    assert_down_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state == ST_COUNT_DOWN && !pend_valid && timer != '0)
        |=> timer == TW'($past(timer) - TW'(1)));

    assert_up_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state == ST_COUNT_UP && !pend_valid && timer == limit)
        |=> (timer == '0) && flag);

    assert_down_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state == ST_COUNT_DOWN && !pend_valid && timer == '0)
        |=> (timer == $past(limit)) && flag);

    assert_flag_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(tick));

    assert_pending_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pend_valid) |=> timer == $past(pend_val));

endmodule

bind prescaled_reload_timer ptimer_checker #(.TW(ptimer_pkg::TIMER_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (psc_tick),
    .state      (u_core.state_q),
    .pend_valid (u_core.pend_valid_q),
    .pend_val   (u_core.pend_q),
    .limit      (u_core.limit),
    .timer      (timer_value),
    .flag       (ovf_flag)
);

// File: tb/test_prescaled_reload_timer.sv
module test_prescaled_reload_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] timer_value;
    logic        ovf_flag;

    int vecs = 0;
    int errs = 0;
    bit done = 1'b0;

    prescaled_reload_timer i_prescaled_reload_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .timer_value(timer_value), .ovf_flag(ovf_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a negedge; returns at the negedge after the write edge.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_peek(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic load_timer(input logic [15:0] v);
        wr(3'd1, v[15:8]);
        wr(3'd0, v[7:0]);
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R1 timer", timer_value, 16'h0);
        chk("R1 flag", {15'b0, ovf_flag}, 16'h0);
        rd_peek(3'd2, d); chk("R1 reload lo", {8'h0, d}, 16'h0);
        rd_peek(3'd3, d); chk("R1 reload hi", {8'h0, d}, 16'h0);
        rd_peek(3'd6, d); chk("R1 ctrl", {8'h0, d}, 16'h0);
    endtask

    task automatic t_pending;
        wr(3'd4, 8'hFC);
        wr(3'd1, 8'h12);
        wr(3'd0, 8'h34);
        chk("R9 held after write", timer_value, 16'h0000);
        @(negedge clk);
        chk("R9 held until tick", timer_value, 16'h0000);
        @(negedge clk);
        chk("R9 loaded on tick", timer_value, 16'h1234);
        wr(3'd4, 8'hFF);
    endtask

    task automatic t_stop;
        repeat (5) @(negedge clk);
        chk("R4 stopped holds", timer_value, 16'h1234);
    endtask

    task automatic t_coherent;
        logic [7:0] d;
        load_timer(16'h00FE);
        chk("R9 stopped load", timer_value, 16'h00FE);
        wr(3'd6, 8'h01);
        chk("R4 mode 01 start edge", timer_value, 16'h00FE);
        bus_rd = 1'b1;
        rd_peek(3'd0, d);
        chk("R10 low byte", {8'h0, d}, 16'h00FE);
        @(negedge clk);
        bus_rd = 1'b0;
        @(negedge clk);
        chk("R10 live timer moved", timer_value, 16'h0100);
        rd_peek(3'd1, d);
        chk("R10 captured high", {8'h0, d}, 16'h0000);
    endtask

    task automatic t_direction;
        logic [15:0] v;
        logic [7:0]  d;
        v = timer_value;
        wr(3'd6, 8'h05);
        chk("R5 last up step", timer_value, v + 16'd1);
        @(negedge clk);
        chk("R5 first down step", timer_value, v);
        @(negedge clk);
        chk("R5 second down step", timer_value, v - 16'd1);
        rd_peek(3'd6, d);
        chk("R5 ctrl readback", {8'h0, d}, 16'h0005);
    endtask

    task automatic t_up_wrap;
        wr(3'd6, 8'h00);
        wr(3'd7, 8'h01);
        wr(3'd2, 8'h05);
        wr(3'd3, 8'h00);
        load_timer(16'h0003);
        wr(3'd6, 8'h02);
        chk("R6 start", timer_value, 16'h0003);
        @(negedge clk);
        @(negedge clk);
        chk("R6 at limit", timer_value, 16'h0005);
        chk("R6 flag before wrap", {15'b0, ovf_flag}, 16'h0);
        @(negedge clk);
        chk("R6 wrap to zero", timer_value, 16'h0000);
        chk("R6 flag on wrap", {15'b0, ovf_flag}, 16'h1);
        wr(3'd6, 8'h00);
        wr(3'd7, 8'h01);
        wr(3'd2, 8'h00);
        load_timer(16'hFFFE);
        wr(3'd6, 8'h03);
        @(negedge clk);
        chk("R6 zero reload reaches FFFF", timer_value, 16'hFFFF);
        chk("R6 no flag at FFFF", {15'b0, ovf_flag}, 16'h0);
        @(negedge clk);
        chk("R6 zero reload wraps", timer_value, 16'h0000);
        chk("R6 flag FFFF wrap", {15'b0, ovf_flag}, 16'h1);
    endtask

    task automatic t_down;
        wr(3'd6, 8'h00);
        wr(3'd7, 8'h01);
        wr(3'd2, 8'h05);
        load_timer(16'h0001);
        wr(3'd6, 8'h05);
        @(negedge clk);
        chk("R7 reach zero", timer_value, 16'h0000);
        chk("R7 flag before", {15'b0, ovf_flag}, 16'h0);
        @(negedge clk);
        chk("R7 reload", timer_value, 16'h0005);
        chk("R7 flag set", {15'b0, ovf_flag}, 16'h1);
    endtask

    task automatic t_flag;
        logic [7:0] d;
        wr(3'd6, 8'h00);
        wr(3'd7, 8'h00);
        chk("R8 write 0 keeps flag", {15'b0, ovf_flag}, 16'h1);
        rd_peek(3'd7, d);
        chk("R8 flag readback", {8'h0, d}, 16'h0001);
        wr(3'd7, 8'h01);
        chk("R8 write 1 clears", {15'b0, ovf_flag}, 16'h0);
    endtask

    task automatic t_prescale;
        logic [15:0] v0;
        wr(3'd2, 8'h00);
        wr(3'd6, 8'h01);
        wr(3'd4, 8'hFE);
        v0 = timer_value;
        @(negedge clk);
        chk("R3 restart delays tick", timer_value, v0);
        @(negedge clk);
        chk("R2 first tick", timer_value, v0 + 16'd1);
        @(negedge clk); @(negedge clk);
        chk("R2 second tick", timer_value, v0 + 16'd2);
        @(negedge clk);
        chk("R2 between ticks", timer_value, v0 + 16'd2);
        @(negedge clk);
        chk("R2 third tick", timer_value, v0 + 16'd3);
    endtask

    task automatic t_conflict;
        wr(3'd6, 8'h00);
        wr(3'd4, 8'hFF);
        wr(3'd7, 8'h01);
        wr(3'd2, 8'h05);
        load_timer(16'h0005);
        chk("R11 setup", timer_value, 16'h0005);
        wr(3'd4, 8'hFC);
        wr(3'd6, 8'h01);
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h40);
        chk("R11 before tick", timer_value, 16'h0005);
        @(negedge clk);
        chk("R11 pending beats wrap", timer_value, 16'h0040);
        chk("R11 no flag", {15'b0, ovf_flag}, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        wr(3'd5, 8'h03);
        wr(3'd4, 8'hFF);
        t_pending();
        t_stop();
        t_coherent();
        t_direction();
        t_up_wrap();
        t_down();
        t_flag();
        t_prescale();
        t_conflict();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

endmodule